// File: doc/BRIEF.md
# External Interrupt Subclass Arbiter

This block holds the pending state of a processor's external-interrupt sources and, when the core is ready to take one, picks the one to deliver. There are five sources: emergency signals from other processors, an external call, the clock comparator, the CPU timer and a service signal. The emergency source is kept as a bitmap with one bit per sending processor. The external call latches the address of the processor that sent it. The service signal comes from an outside queue, which presents an available flag and a 32-bit parameter.

Each source takes part only when its subclass-mask bit is set. Among the sources that take part, a fixed priority chain picks the winner. When `accept` is pulsed, the block reports the winner's 16-bit interruption code, the processor address and the parameter one cycle later, and it clears the winner's pending state. For the service source, it pops the outside queue in the accept cycle. If `accept` arrives while no source can take part, the block flags an error instead.

Top module: `ext_irq_arbiter`

## Requirements
- R1: Among eligible sources the priority is emergency, then external call, then clock comparator, then CPU timer, then service; `irq_req_o` is high whenever any source is eligible.
- R2: A source is eligible only when its `sub_mask_i` bit is set; bit 0 is emergency, bit 1 external call, bit 2 clock comparator, bit 3 CPU timer and bit 4 service.
- R3: An emergency delivery reports as processor address the lowest set index of the emergency bitmap, and it clears only that bit.
- R4: The emergency source stays pending, and keeps its priority over lower sources, until the last bit of its bitmap has been delivered.
- R5: `xcall_set_i` latches `xcall_addr_i`. An external-call delivery reports that latched address and clears the external-call pending state.
- R6: Clock comparator and CPU timer deliveries report processor address 0 and clear only their own pending flag.
- R7: A service delivery raises `svc_pop_o` combinationally in the accept cycle and reports `svc_param_i` with processor address 0. The block keeps no service state of its own.
- R8: An accept while nothing is eligible produces a one-cycle `err_o` pulse, no `dlv_vld_o`, and no change to any pending state.
- R9: Outputs are registered. `dlv_vld_o` pulses in the cycle after an accepting edge, with code 0x1201 for emergency, 0x1202 for external call, 0x1004 for clock comparator, 0x1005 for CPU timer and 0x2401 for service. Parameter is 0 except for service.
- R10: A set strobe that arrives in the same cycle as the delivery of that same source wins, so the new event stays pending.
- R11: After reset nothing is pending, and `irq_req_o`, `dlv_vld_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| emg_set_i | input | NCPU | One bit per sending processor; sets that bit of the emergency bitmap |
| xcall_set_i | input | 1 | Sets external call pending and latches its source address |
| xcall_addr_i | input | 16 | Source processor address of the external call |
| ckc_set_i | input | 1 | Sets clock comparator pending |
| cpt_set_i | input | 1 | Sets CPU timer pending |
| svc_avail_i | input | 1 | Outside service queue is non-empty |
| svc_param_i | input | 32 | Parameter at the head of the service queue |
| sub_mask_i | input | 5 | Subclass mask bits, one per source |
| accept_i | input | 1 | Core takes the highest eligible source this cycle |
| irq_req_o | output | 1 | Some source is eligible |
| svc_pop_o | output | 1 | Pop strobe to the service queue |
| dlv_vld_o | output | 1 | Delivery outputs valid (one-cycle pulse) |
| dlv_code_o | output | 16 | Interruption code of the delivered source |
| dlv_addr_o | output | 16 | Processor address of the delivered source |
| dlv_param_o | output | 32 | Parameter of the delivered source |
| err_o | output | 1 | Accept with nothing eligible (one-cycle pulse) |

## Verification
The bench puts all five sources up at once and drains them, so a priority chain with swapped links shows up as a wrong code order. It loads three emergency bits out of order while an external call waits. A search for the highest bit would report the wrong addresses, and a flag that is cleared on the first delivery would let the external call jump ahead. It then accepts with every mask bit clear. A design that drops pending state on a failed accept, or that raises a false delivery, would lose the clock comparator that follows. Last, it sets a source in the same cycle it is delivered. A design where the clear wins would drop that second event.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int NSRC = 5;
  localparam int S_EMG = 0;
  localparam int S_XC  = 1;
  localparam int S_CKC = 2;
  localparam int S_CPT = 3;
  localparam int S_SVC = 4;

  localparam logic [15:0] CODE_EMG = 16'h1201;
  localparam logic [15:0] CODE_XC  = 16'h1202;
  localparam logic [15:0] CODE_CKC = 16'h1004;
  localparam logic [15:0] CODE_CPT = 16'h1005;
  localparam logic [15:0] CODE_SVC = 16'h2401;

  // interruption code for a one-hot source selection
  function automatic logic [15:0] code_of(input logic [NSRC-1:0] sel);
    logic [15:0] c;
    c = 16'h0000;
    if (sel[S_EMG]) c = CODE_EMG;
    if (sel[S_XC])  c = CODE_XC;
    if (sel[S_CKC]) c = CODE_CKC;
    if (sel[S_CPT]) c = CODE_CPT;
    if (sel[S_SVC]) c = CODE_SVC;
    return c;
  endfunction
endpackage

// File: rtl/ext_lowest_set.sv
module ext_lowest_set #(
  parameter int W  = 16,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  bit_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
    bit_o = found_o ? (W'(1) << idx_o) : '0;
  end
endmodule

// File: rtl/ext_prio_chain.sv
module ext_prio_chain #(
  parameter int N = 5
) (
  input  logic [N-1:0] elig_i,
  output logic [N-1:0] sel_o,
  output logic         any_o
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;
  for (genvar k = 0; k < N; k++) begin : g_link
    assign blocked[k+1] = blocked[k] | elig_i[k];
    assign sel_o[k]     = elig_i[k] & ~blocked[k];
  end
  assign any_o = blocked[N];
endmodule

// File: rtl/ext_irq_arbiter.sv
module ext_irq_arbiter
  import ext_irq_pkg::*;
#(
  parameter int NCPU   = 16,
  parameter int ADDR_W = 16,
  parameter int PARM_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCPU-1:0]   emg_set_i,
  input  logic              xcall_set_i,
  input  logic [ADDR_W-1:0] xcall_addr_i,
  input  logic              ckc_set_i,
  input  logic              cpt_set_i,
  input  logic              svc_avail_i,
  input  logic [PARM_W-1:0] svc_param_i,
  input  logic [NSRC-1:0]   sub_mask_i,
  input  logic              accept_i,
  output logic              irq_req_o,
  output logic              svc_pop_o,
  output logic              dlv_vld_o,
  output logic [15:0]       dlv_code_o,
  output logic [ADDR_W-1:0] dlv_addr_o,
  output logic [PARM_W-1:0] dlv_param_o,
  output logic              err_o
);
  localparam int IW = (NCPU > 1) ? $clog2(NCPU) : 1;

  logic [NCPU-1:0]   emg_map;
  logic              emg_pend, xc_pend, ckc_pend, cpt_pend;
  logic [ADDR_W-1:0] xc_addr;

  logic [NSRC-1:0]   pend_vec, elig, sel;
  logic              any_elig, take;
  logic              low_found;
  logic [IW-1:0]     low_idx;
  logic [NCPU-1:0]   low_bit, emg_clr, map_nxt;
  logic              take_emg, take_xc, take_ckc, take_cpt;

  assign pend_vec = {svc_avail_i, cpt_pend, ckc_pend, xc_pend, emg_pend};
  assign elig     = pend_vec & sub_mask_i;

  ext_prio_chain #(.N(NSRC)) u_chain (
    .elig_i (elig),
    .sel_o  (sel),
    .any_o  (any_elig)
  );

  ext_lowest_set #(.W(NCPU)) u_low (
    .vec_i   (emg_map),
    .found_o (low_found),
    .idx_o   (low_idx),
    .bit_o   (low_bit)
  );

  assign take     = accept_i & any_elig;
  assign take_emg = take & sel[S_EMG];
  assign take_xc  = take & sel[S_XC];
  assign take_ckc = take & sel[S_CKC];
  assign take_cpt = take & sel[S_CPT];
  assign emg_clr  = take_emg ? low_bit : '0;
  assign map_nxt  = (emg_map & ~emg_clr) | emg_set_i;

  assign irq_req_o = any_elig;
  assign svc_pop_o = take & sel[S_SVC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emg_map  <= '0;
      emg_pend <= 1'b0;
      xc_pend  <= 1'b0;
      xc_addr  <= '0;
      ckc_pend <= 1'b0;
      cpt_pend <= 1'b0;
    end else begin
      emg_map <= map_nxt;
      if (|emg_set_i)                 emg_pend <= 1'b1;
      else if (take_emg && !(|map_nxt)) emg_pend <= 1'b0;
      if (xcall_set_i) begin
        xc_pend <= 1'b1;
        xc_addr <= xcall_addr_i;
      end else if (take_xc) begin
        xc_pend <= 1'b0;
      end
      if (ckc_set_i)     ckc_pend <= 1'b1;
      else if (take_ckc) ckc_pend <= 1'b0;
      if (cpt_set_i)     cpt_pend <= 1'b1;
      else if (take_cpt) cpt_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dlv_vld_o   <= 1'b0;
      dlv_code_o  <= '0;
      dlv_addr_o  <= '0;
      dlv_param_o <= '0;
      err_o       <= 1'b0;
    end else begin
      dlv_vld_o <= take;
      err_o     <= accept_i & ~any_elig;
      if (take) begin
        dlv_code_o  <= code_of(sel);
        dlv_addr_o  <= sel[S_EMG] ? ADDR_W'(low_idx) :
                       sel[S_XC]  ? xc_addr : '0;
        dlv_param_o <= sel[S_SVC] ? svc_param_i : '0;
      end
    end
  end

  // ---------------- assertions ----------------
  p_sel_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((sel & ~sub_mask_i) == '0) && (sel != '0));

  p_emg_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && emg_pend && sub_mask_i[S_EMG]) |=> (dlv_code_o == CODE_EMG));

  p_emg_one_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_emg && emg_set_i == '0) |=>
      ($countones(emg_map) + 1 == $countones($past(emg_map))));

  p_pend_tracks_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
    emg_pend == (|emg_map));

  p_xc_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_xc && !xcall_set_i) |=> !xc_pend);

  p_pop_needs_svc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_pop_o |-> (svc_avail_i && sub_mask_i[S_SVC]));

  p_err_no_dlv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && !irq_req_o) |=> (err_o && !dlv_vld_o));

  p_err_keeps_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && !irq_req_o && emg_set_i == '0) |=> $stable(emg_map));

  p_dlv_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && irq_req_o) |=> dlv_vld_o);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ckc && ckc_set_i) |=> ckc_pend);
endmodule

// File: tb/ext_irq_arbiter_tb_top.sv
module ext_irq_arbiter_tb_top;
  localparam int NCPU = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCPU-1:0] emg_set = '0;
  logic xcall_set = 1'b0;
  logic [15:0] xcall_addr = '0;
  logic ckc_set = 1'b0, cpt_set = 1'b0, svc_avail = 1'b0;
  logic [31:0] svc_param = '0;
  logic [4:0] sub_mask = '0;
  logic accept = 1'b0;
  logic irq_req, svc_pop, dlv_vld, err;
  logic [15:0] dlv_code, dlv_addr;
  logic [31:0] dlv_param;

  int n_run = 0;
  int n_fail = 0;

  logic g_pop, g_vld, g_err;
  logic [15:0] g_code, g_addr;
  logic [31:0] g_param;

  always #4 clk = ~clk;

  ext_irq_arbiter #(.NCPU(NCPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .emg_set_i(emg_set), .xcall_set_i(xcall_set),
    .xcall_addr_i(xcall_addr), .ckc_set_i(ckc_set), .cpt_set_i(cpt_set),
    .svc_avail_i(svc_avail), .svc_param_i(svc_param), .sub_mask_i(sub_mask),
    .accept_i(accept), .irq_req_o(irq_req), .svc_pop_o(svc_pop),
    .dlv_vld_o(dlv_vld), .dlv_code_o(dlv_code), .dlv_addr_o(dlv_addr),
    .dlv_param_o(dlv_param), .err_o(err)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one accept; pop sampled in the accept cycle, registered outputs one cycle later
  task automatic do_accept();
    @(negedge clk);
    accept = 1'b1;
    #1 g_pop = svc_pop;
    @(negedge clk);
    accept = 1'b0;
    g_vld = dlv_vld; g_err = err; g_code = dlv_code;
    g_addr = dlv_addr; g_param = dlv_param;
  endtask

  task automatic expect_dlv(input string req, input logic [15:0] code,
                            input logic [15:0] addr, input logic [31:0] parm);
    do_accept();
    chk(g_vld == 1'b1, req, g_vld, 1);
    chk(g_code == code, req, g_code, code);
    chk(g_addr == addr, req, g_addr, addr);
    chk(g_param == parm, req, g_param, parm);
  endtask

  task automatic pulse_sets(input logic [NCPU-1:0] e, input logic xc, input logic [15:0] xa,
                            input logic ck, input logic ct);
    @(negedge clk);
    emg_set = e; xcall_set = xc; xcall_addr = xa; ckc_set = ck; cpt_set = ct;
    @(negedge clk);
    emg_set = '0; xcall_set = 1'b0; xcall_addr = '0; ckc_set = 1'b0; cpt_set = 1'b0;
  endtask

  task automatic t_reset();
    chk(irq_req == 1'b0, "R11", irq_req, 0);
    chk(dlv_vld == 1'b0, "R11", dlv_vld, 0);
    chk(err == 1'b0, "R11", err, 0);
  endtask

  task automatic t_priority();
    sub_mask = 5'b11111;
    svc_avail = 1'b1; svc_param = 32'hDEADBEEF;
    pulse_sets(16'h0020, 1'b1, 16'h0ABC, 1'b1, 1'b1);
    chk(irq_req == 1'b1, "R1", irq_req, 1);
    expect_dlv("R1 R3 R9 emergency", 16'h1201, 16'd5, 32'h0);
    expect_dlv("R1 R5 R9 external call", 16'h1202, 16'h0ABC, 32'h0);
    expect_dlv("R1 R6 R9 clock comparator", 16'h1004, 16'h0, 32'h0);
    expect_dlv("R1 R6 R9 cpu timer", 16'h1005, 16'h0, 32'h0);
    chk(g_pop == 1'b0, "R7 no pop on timer", g_pop, 0);
    expect_dlv("R7 R9 service", 16'h2401, 16'h0, 32'hDEADBEEF);
    chk(g_pop == 1'b1, "R7 pop", g_pop, 1);
    svc_avail = 1'b0;
    #1 chk(irq_req == 1'b0, "R6 R5 all cleared", irq_req, 0);
  endtask

  task automatic t_mask();
    pulse_sets('0, 1'b0, 16'h0, 1'b1, 1'b1);
    sub_mask = 5'b01000;
    expect_dlv("R2 only timer enabled", 16'h1005, 16'h0, 32'h0);
    sub_mask = 5'b00000;
    #1 chk(irq_req == 1'b0, "R2 masked", irq_req, 0);
    do_accept();
    chk(g_err == 1'b1, "R8 err", g_err, 1);
    chk(g_vld == 1'b0, "R8 no delivery", g_vld, 0);
    @(negedge clk);
    chk(err == 1'b0, "R8 err one cycle", err, 0);
    sub_mask = 5'b00100;
    expect_dlv("R8 ckc kept after failed accept", 16'h1004, 16'h0, 32'h0);
    sub_mask = 5'b11111;
    #1 chk(irq_req == 1'b0, "R6 nothing left", irq_req, 0);
  endtask

  task automatic t_emg_order();
    pulse_sets(16'h8204, 1'b1, 16'h0077, 1'b0, 1'b0);
    expect_dlv("R3 lowest first", 16'h1201, 16'd2, 32'h0);
    expect_dlv("R3 R4 next bit", 16'h1201, 16'd9, 32'h0);
    expect_dlv("R3 R4 last bit", 16'h1201, 16'd15, 32'h0);
    expect_dlv("R4 xcall after map empty", 16'h1202, 16'h0077, 32'h0);
    #1 chk(irq_req == 1'b0, "R4 emergency cleared", irq_req, 0);
  endtask

  task automatic t_set_wins();
    pulse_sets('0, 1'b0, 16'h0, 1'b1, 1'b0);
    @(negedge clk);
    accept = 1'b1; ckc_set = 1'b1;
    @(negedge clk);
    accept = 1'b0; ckc_set = 1'b0;
    chk(dlv_code == 16'h1004, "R10 first ckc", dlv_code, 16'h1004);
    chk(irq_req == 1'b1, "R10 ckc still pending", irq_req, 1);
    expect_dlv("R10 second ckc", 16'h1004, 16'h0, 32'h0);
    pulse_sets(16'h0008, 1'b0, 16'h0, 1'b0, 1'b0);
    @(negedge clk);
    accept = 1'b1; emg_set = 16'h0008;
    @(negedge clk);
    accept = 1'b0; emg_set = '0;
    chk(dlv_addr == 16'd3, "R10 emg first", dlv_addr, 3);
    expect_dlv("R10 emg bit re-set", 16'h1201, 16'd3, 32'h0);
    #1 chk(irq_req == 1'b0, "R10 drained", irq_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_priority();
    t_mask();
    t_emg_order();
    t_set_wins();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule